// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits each (32 by default) and returns their full `2N`-bit signed product. It recodes the multiplier in radix-2 Booth fashion. One iteration runs per clock, and all iterations share a single adder/subtractor. The multiplier is not kept in a register of its own. It sits in the low half of a combined product register, with one guard bit below it. Each iteration inspects the two lowest bits of that register, adds or subtracts the latched multiplicand into the high half or leaves it alone, and then shifts the whole register right by one with sign extension.

The surrounding logic pulses `start_i` while the block is idle, with both operands valid in that cycle. The block latches the operands and raises `busy_o` for exactly `N` cycles. It then pulses `done_o` for one cycle. The product stays on `product_o` until the next accepted start.

The controller has three states:
- `ST_IDLE` waits for a start. A start moves it to `ST_RUN`, loads the register and latches the multiplicand.
- `ST_RUN` performs one iteration per cycle. After the `N`-th iteration it moves to `ST_FIN`.
- `ST_FIN` drives the done pulse and always returns to `ST_IDLE` on the next cycle.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` high at a clock edge while the block is idle (neither busy nor done) is accepted. `busy_o` is 1 from the next cycle onward for exactly `N` consecutive cycles.
- R3: `done_o` is 1 for exactly one cycle, the cycle right after the last busy cycle, which is N+1 cycles after the accepting edge. `busy_o` and `done_o` are never 1 together.
- R4: While `done_o` is 1, `product_o` equals the signed product of the two operands latched at acceptance, as a `2N`-bit two's-complement value.
- R5: The result is exact when either operand or both equal the most negative value -2^(N-1), including (-2^(N-1)) x (-2^(N-1)) = 2^(2N-2).
- R6: A `start_i` while `busy_o` or `done_o` is 1 is ignored. The run in progress completes with its own product and its own timing.
- R7: After `done_o`, `product_o` keeps its value for every cycle until a start is accepted.
- R8: Changes on `mcand_i` and `mplier_i` after the accepting edge do not affect the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication when idle |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Signed product |

## Verification
Directed operands test several behaviours of the Booth recoding:
- Small positive pairs check plain accumulation.
- Mixed signs check the subtract-then-add pairs.
- A multiplier of all ones gives one long run of ones.
- Alternating bit patterns force an add or subtract in every iteration.
- Most-negative operands show whether the sign bit shifted in at each step comes from the true sum or from a truncated one.

Random operands from a fixed seed cover the general space. During some random runs the bench also scrambles the inputs and pulses start in the middle of the run and in the done cycle. This separates a block that latches its operands and ignores late starts from one that does not.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_ADD,
        OP_SUB
    } booth_op_e;

    // Map the (current, guard) bit pair to the arithmetic step.
    function automatic booth_op_e recode(input logic [1:0] pair);
        booth_op_e op;
        unique case (pair)
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_fsm.sv
module booth_fsm
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    booth_state_e state_q, state_d;
    logic [CW-1:0] iter_q;

    // State and iteration counter register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                iter_q <= '0;
            end else if (state_q == ST_RUN) begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_FIN:  done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_alu.sv
module booth_alu
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] hi_i,
    input  logic [N-1:0] mcand_i,
    input  logic [1:0]   pair_i,
    output logic [N:0]   sum_o
);

    // One guard bit so the sign of the true result is kept even for -2^(N-1).
    logic [N:0] hi_x, mc_x;

    assign hi_x = {hi_i[N-1], hi_i};
    assign mc_x = {mcand_i[N-1], mcand_i};

    always_comb begin
        unique case (recode(pair_i))
            OP_ADD:  sum_o = hi_x + mc_x;
            OP_SUB:  sum_o = hi_x - mc_x;
            default: sum_o = hi_x;
        endcase
    end

endmodule

// File: rtl/booth_preg.sv
module booth_preg #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [N-1:0]   mplier_i,
    input  logic [N:0]     sum_i,
    output logic [2*N:0]   preg_o
);

    // Layout: [2N:N+1] high half, [N:1] low half, [0] guard bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preg_o <= '0;
        end else if (load_i) begin
            preg_o <= {{N{1'b0}}, mplier_i, 1'b0};
        end else if (step_i) begin
            // Concatenating the N+1 bit sum with the old low half is the arithmetic shift.
            preg_o <= {sum_i, preg_o[N:1]};
        end
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);

    localparam int PW = 2 * N + 1;

    logic          load, step;
    logic [N-1:0]  mcand_q;
    logic [N:0]    sum;
    logic [PW-1:0] preg;

    booth_fsm #(.N(N)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
        end else if (load) begin
            mcand_q <= mcand_i;
        end
    end

    booth_alu #(.N(N)) alu_i (
        .hi_i    (preg[PW-1:N+1]),
        .mcand_i (mcand_q),
        .pair_i  (preg[1:0]),
        .sum_o   (sum)
    );

    booth_preg #(.N(N)) preg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mplier_i (mplier_i),
        .sum_i    (sum),
        .preg_o   (preg)
    );

    assign product_o = preg[PW-1:1];

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] product_o
);

    localparam int CW = $clog2(N + 2);

    logic                  accept;
    logic [CW-1:0]         run_len;
    logic signed [2*N-1:0] ea, eb, exp_q;

    assign accept = start_i && !busy_o && !done_o;
    assign ea = {{N{mcand_i[N-1]}}, mcand_i};
    assign eb = {{N{mplier_i[N-1]}}, mplier_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            exp_q   <= '0;
        end else begin
            run_len <= busy_o ? run_len + 1'b1 : '0;
            if (accept) exp_q <= ea * eb;
        end
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == CW'(N)));

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R4, R5, R6 and R8: the product against operands captured at acceptance.
    p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == exp_q));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !accept) |=> $stable(product_o));

endmodule

bind booth_mul booth_mul_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/booth_mul_tb_top.sv
`timescale 1ns/1ps
module booth_mul_tb_top;

    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [N-1:0]   mcand_i = '0;
    logic [N-1:0]   mplier_i = '0;
    logic           busy_o, done_o;
    logic [2*N-1:0] product_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    booth_mul #(.N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [2*N-1:0] xa, xb;
        xa = {{N{a[N-1]}}, a};
        xb = {{N{b[N-1]}}, b};
        return xa * xb;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One multiplication. Optionally disturb the inputs during the run and in the done cycle.
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input logic disturb);
        logic [2*N-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        start_i  = 1'b1;
        mcand_i  = a;
        mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1 && done_o == 1'b0, "R2 busy after start", 64'(busy_o), 64'(1));
        for (int k = 2; k <= N; k++) begin
            if (disturb) begin
                start_i  = (k % 5 == 0);
                mcand_i  = $urandom;
                mplier_i = $urandom;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (busy_o !== 1'b1 || done_o !== 1'b0)
                chk(1'b0, "R2 busy window", {62'd0, busy_o, done_o}, 64'd2);
        end
        if (disturb) begin
            mcand_i  = $urandom;
            mplier_i = $urandom;
        end
        @(negedge clk);
        chk(done_o == 1'b1 && busy_o == 1'b0, "R3 done timing", {62'd0, busy_o, done_o}, 64'd1);
        chk(product_o == exp, disturb ? "R4 R6 R8 product" : "R4 product", product_o, exp);
        // A start in the done cycle must be ignored (R6).
        if (disturb) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0 && busy_o == 1'b0, "R3 R6 done pulse width", {62'd0, busy_o, done_o}, 64'd0);
        @(negedge clk);
        chk(product_o == exp && busy_o == 1'b0, "R7 product hold", product_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] mn;
        mn = {1'b1, {(N-1){1'b0}}};
        void'($urandom(32'h5eed_b007));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && product_o == '0, "R1 reset", product_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && product_o == '0, "R1 after reset", product_o, '0);

        run_op(32'd2, 32'd7, 1'b0);                 // R4 small positive
        run_op(32'd2, -32'sd3, 1'b0);               // R4 mixed sign
        run_op(-32'sd7, -32'sd7, 1'b0);             // R4 both negative
        run_op(32'h1234_5678, 32'hFFFF_FFFF, 1'b0); // R4 long run of ones
        run_op(32'h7FFF_FFFF, 32'h5555_5555, 1'b0); // R4 alternating pairs
        run_op(mn, mn, 1'b0);                       // R5 most negative squared
        run_op(mn, 32'h7FFF_FFFF, 1'b0);            // R5
        run_op(32'hAAAA_AAAA, mn, 1'b0);            // R5
        run_op(mn, 32'hAAAA_AAAA, 1'b0);            // R5 alternating subtracts of -2^(N-1)
        run_op(32'd0, 32'hDEAD_BEEF, 1'b0);         // R4 zero operand
        run_op(32'hCAFE_F00D, 32'd1, 1'b1);         // R6 R8 disturbed run
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] a, b;
            a = $urandom;
            b = $urandom;
            run_op(a, b, i[0]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule